// File: doc/BRIEF.md
# Translation Cache with Access Protection

This block holds a small set of recently used page-to-frame translations and answers address lookups in the same cycle they are presented. A lookup carries a virtual address and an access kind (read, write or instruction fetch). The virtual page number is compared against every stored entry at once. On a hit, the block forms the physical address by placing the stored frame number above the unchanged page offset. No page-table memory access is needed.

Each lookup is also checked against two things. The first is an upper bound on the page number, supplied by the surrounding processor state. The second is the permission flags of the matching entry. At most one fault code is reported per lookup, in a fixed priority order.

When a lookup misses, an outside refill agent (a hardware walker or kernel software) writes the translation through a dedicated write port. The block itself picks the slot that receives it. A flush input invalidates every entry at once, for use on a context switch.

Top module: `xlat_cache`

## Requirements
- R1: After synchronous reset, no entry is valid, so every lookup within the page limit reports a miss; the round-robin pointer starts at slot 0.
- R2: A lookup compares its page number against all valid entries in parallel. A match with sufficient permission raises `lk_hit` combinationally in the same cycle, and `lk_paddr` equals the stored frame number concatenated above the page offset.
- R3: The low `PAGE_BITS` bits of `lk_paddr` on a hit equal the low `PAGE_BITS` bits of `lk_vaddr`.
- R4: A lookup whose page number is strictly greater than `page_limit` reports fault code 1 (limit), even if a matching entry exists. A page number equal to the limit is allowed.
- R5: A lookup within the limit whose page number matches no valid entry reports fault code 2 (miss).
- R6: Permission bits are bit 0 read, bit 1 write, bit 2 execute. Access codes are 0 read, 1 write, 2 execute; code 3 is never permitted. A matching entry that lacks the bit for the requested access reports fault code 3 (protection), with `lk_hit` low and `lk_paddr` zero.
- R7: Exactly one outcome is reported per lookup. The priority is limit, then miss, then protection. A hit reports fault code 0.
- R8: A refill write takes effect from the next cycle. When no entry holds the written page, the write goes to the lowest-numbered invalid slot, so no existing translation is displaced while free slots remain.
- R9: When all slots are valid and the written page is absent, the write replaces the slot named by a round-robin pointer. The pointer then advances by one, wrapping after the last slot.
- R10: A refill write whose page number is already held by a valid entry overwrites that entry in place. It does not move the round-robin pointer and does not disturb other entries.
- R11: Asserting `flush` invalidates all entries from the next cycle. A refill write presented in the same cycle as `flush` is dropped.
- R12: When `lk_valid` is low, `lk_hit` is low, `lk_fault` is 0 and `lk_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | VPN_W+PAGE_BITS | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| page_limit | input | VPN_W | Highest permitted page number |
| lk_hit | output | 1 | Translation succeeded |
| lk_fault | output | 2 | 0 none, 1 limit, 2 miss, 3 protection |
| lk_paddr | output | PFN_W+PAGE_BITS | Translated physical address, zero unless hit |
| wr_en | input | 1 | Refill write strobe |
| wr_vpn | input | VPN_W | Page number of the refill |
| wr_pfn | input | PFN_W | Frame number of the refill |
| wr_perm | input | 3 | Permission flags of the refill |

## Verification
The checker watches every cycle for the properties that hold regardless of stored contents. An idle lookup must stay silent. A hit must carry fault code 0 and the untouched page offset. An out-of-limit page must always report the limit fault. A protection fault must never leak an address, and a reset or flush must be followed by a cycle without any hit. The rest depends on what the entries hold, and only the directed scenarios can show it: which slot a refill lands in, in-place overwrite of a present page, round-robin eviction order, the dropped write under flush, and the exact frame returned.

// File: rtl/xlat_pkg.sv
// Shared encodings for the translation cache: access kinds, fault codes
// and positions of the permission flags.
package xlat_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_LIMIT = 2'd1,
        FLT_MISS  = 2'd2,
        FLT_PERM  = 2'd3
    } fault_e;

    localparam int PERM_BITS = 3;
    localparam int PERM_RD   = 0;
    localparam int PERM_WR   = 1;
    localparam int PERM_EX   = 2;
endpackage

// File: rtl/xlat_entry_array.sv
// Entry storage and parallel comparators.
// Assumes ENTRIES >= 2 and that wr_idx is supplied by the victim selector.
// Every entry is compared both with the lookup page and with the refill
// page, so the selector can detect a page that is already present.
module xlat_entry_array #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [VPN_W-1:0]              wr_vpn,
    input  logic [PFN_W-1:0]              wr_pfn,
    input  logic [xlat_pkg::PERM_BITS-1:0] wr_perm,
    input  logic [VPN_W-1:0]              lk_vpn,
    output logic [ENTRIES-1:0]            valid_vec,
    output logic [ENTRIES-1:0]            dup_vec,
    output logic                          any_match,
    output logic [PFN_W-1:0]              hit_pfn,
    output logic [xlat_pkg::PERM_BITS-1:0] hit_perm
);
    logic [VPN_W-1:0]               vpn_q  [ENTRIES];
    logic [PFN_W-1:0]               pfn_q  [ENTRIES];
    logic [xlat_pkg::PERM_BITS-1:0] perm_q [ENTRIES];
    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0]             match_vec;

    // Update storage: reset and flush clear valid bits, refill fills one slot.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= '0;
            if (!rst_n) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    vpn_q[i]  <= '0;
                    pfn_q[i]  <= '0;
                    perm_q[i] <= '0;
                end
            end
        end else if (wr_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_idx == IDX_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    vpn_q[i]   <= wr_vpn;
                    pfn_q[i]   <= wr_pfn;
                    perm_q[i]  <= wr_perm;
                end
            end
        end
    end

    // One lookup comparator and one refill comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
        assign dup_vec[g]   = valid_q[g] && (vpn_q[g] == wr_vpn);
    end

    // OR-mux the matching entry's frame and flags (at most one matches).
    always_comb begin
        hit_pfn  = '0;
        hit_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                hit_pfn  = hit_pfn  | pfn_q[i];
                hit_perm = hit_perm | perm_q[i];
            end
        end
    end

    assign any_match = |match_vec;
    assign valid_vec = valid_q;
endmodule

// File: rtl/xlat_victim.sv
// Picks the slot that a refill write lands in.
// Priority: the slot already holding the page, then the lowest invalid
// slot, then the round-robin pointer. The pointer moves only when it is used.
module xlat_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] dup_vec,
    output logic [IDX_W-1:0]   wr_idx
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] dup_idx;
    logic [IDX_W-1:0] free_idx;
    logic             have_free;
    logic             have_dup;

    // Encode the lowest duplicate and lowest free slot.
    always_comb begin
        dup_idx   = '0;
        free_idx  = '0;
        have_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (dup_vec[i]) dup_idx = IDX_W'(i);
            if (!valid_vec[i]) begin
                free_idx  = IDX_W'(i);
                have_free = 1'b1;
            end
        end
    end

    assign have_dup = |dup_vec;
    assign wr_idx   = have_dup ? dup_idx : (have_free ? free_idx : rr_q);

    // Advance the round-robin pointer after each eviction of a full array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (wr_en && !flush && !have_dup && !have_free) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_fault.sv
// Resolves a lookup into one outcome: limit fault, miss, protection fault
// or hit. Purely combinational; assumes at most one entry matches.
module xlat_fault #(
    parameter int VPN_W = 20
) (
    input  logic                          lk_valid,
    input  logic [VPN_W-1:0]              lk_vpn,
    input  logic [1:0]                    lk_acc,
    input  logic [VPN_W-1:0]              page_limit,
    input  logic                          any_match,
    input  logic [xlat_pkg::PERM_BITS-1:0] hit_perm,
    output logic                          hit,
    output logic [1:0]                    fault
);
    import xlat_pkg::*;
    logic perm_ok;

    // Decide whether the entry's flags allow the requested access kind.
    always_comb begin
        case (lk_acc)
            ACC_READ:  perm_ok = hit_perm[PERM_RD];
            ACC_WRITE: perm_ok = hit_perm[PERM_WR];
            ACC_EXEC:  perm_ok = hit_perm[PERM_EX];
            default:   perm_ok = 1'b0;
        endcase
    end

    // Apply the fixed priority: limit, miss, protection, then hit.
    always_comb begin
        hit   = 1'b0;
        fault = FLT_NONE;
        if (lk_valid) begin
            if (lk_vpn > page_limit) fault = FLT_LIMIT;
            else if (!any_match)     fault = FLT_MISS;
            else if (!perm_ok)       fault = FLT_PERM;
            else                     hit   = 1'b1;
        end
    end
endmodule

// File: rtl/xlat_cache.sv
// Top of the translation cache. Lookups resolve combinationally in the
// cycle they are presented; refills and flushes take effect next cycle.
// Assumes the refill agent only writes translations it fetched itself.
module xlat_cache #(
    parameter int ENTRIES   = 8,
    parameter int VPN_W     = 20,
    parameter int PFN_W     = 20,
    parameter int PAGE_BITS = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       lk_valid,
    input  logic [VPN_W+PAGE_BITS-1:0] lk_vaddr,
    input  logic [1:0]                 lk_acc,
    input  logic [VPN_W-1:0]           page_limit,
    output logic                       lk_hit,
    output logic [1:0]                 lk_fault,
    output logic [PFN_W+PAGE_BITS-1:0] lk_paddr,
    input  logic                       wr_en,
    input  logic [VPN_W-1:0]           wr_vpn,
    input  logic [PFN_W-1:0]           wr_pfn,
    input  logic [2:0]                 wr_perm
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [VPN_W-1:0]     lk_vpn;
    logic [PAGE_BITS-1:0] lk_off;
    logic [ENTRIES-1:0]   valid_vec;
    logic [ENTRIES-1:0]   dup_vec;
    logic [IDX_W-1:0]     wr_idx;
    logic                 any_match;
    logic [PFN_W-1:0]     hit_pfn;
    logic [2:0]           hit_perm;

    assign lk_vpn = lk_vaddr[VPN_W+PAGE_BITS-1:PAGE_BITS];
    assign lk_off = lk_vaddr[PAGE_BITS-1:0];

    xlat_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_array (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
        .wr_pfn(wr_pfn), .wr_perm(wr_perm), .lk_vpn(lk_vpn),
        .valid_vec(valid_vec), .dup_vec(dup_vec), .any_match(any_match),
        .hit_pfn(hit_pfn), .hit_perm(hit_perm)
    );

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
        .valid_vec(valid_vec), .dup_vec(dup_vec), .wr_idx(wr_idx)
    );

    xlat_fault #(.VPN_W(VPN_W)) u_fault (
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_acc(lk_acc),
        .page_limit(page_limit), .any_match(any_match),
        .hit_perm(hit_perm), .hit(lk_hit), .fault(lk_fault)
    );

    // Form the physical address only for a successful translation.
    assign lk_paddr = lk_hit ? {hit_pfn, lk_off} : '0;
endmodule

// File: rtl/xlat_cache_chk.sv
// Cycle-by-cycle properties of the translation cache, bound to its top.
module xlat_cache_chk #(
    parameter int VPN_W     = 20,
    parameter int PFN_W     = 20,
    parameter int PAGE_BITS = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       flush,
    input logic                       lk_valid,
    input logic [VPN_W+PAGE_BITS-1:0] lk_vaddr,
    input logic [VPN_W-1:0]           page_limit,
    input logic                       lk_hit,
    input logic [1:0]                 lk_fault,
    input logic [PFN_W+PAGE_BITS-1:0] lk_paddr
);
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && lk_fault == 2'd0 && lk_paddr == '0));

    // R7
    hit_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_fault == 2'd0);

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]);

    // R4
    limit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_vaddr[VPN_W+PAGE_BITS-1:PAGE_BITS] > page_limit)
        |-> (lk_fault == 2'd1 && !lk_hit));

    // R6
    perm_no_leak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault == 2'd3 |-> (lk_paddr == '0 && !lk_hit));

    // R11
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> !lk_hit);
endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W), .PAGE_BITS(PAGE_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
    .lk_vaddr(lk_vaddr), .page_limit(page_limit), .lk_hit(lk_hit),
    .lk_fault(lk_fault), .lk_paddr(lk_paddr)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;
    localparam int ENTRIES = 8;
    localparam int VPN_W = 20;
    localparam int PFN_W = 20;
    localparam int PAGE_BITS = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic lk_valid = 1'b0;
    logic [VPN_W+PAGE_BITS-1:0] lk_vaddr = '0;
    logic [1:0] lk_acc = 2'd0;
    logic [VPN_W-1:0] page_limit = '1;
    logic lk_hit;
    logic [1:0] lk_fault;
    logic [PFN_W+PAGE_BITS-1:0] lk_paddr;
    logic wr_en = 1'b0;
    logic [VPN_W-1:0] wr_vpn = '0;
    logic [PFN_W-1:0] wr_pfn = '0;
    logic [2:0] wr_perm = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xlat_cache #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .PAGE_BITS(PAGE_BITS)) i_xlat_cache (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
        .lk_vaddr(lk_vaddr), .lk_acc(lk_acc), .page_limit(page_limit),
        .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
        .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_pfn(wr_pfn), .wr_perm(wr_perm)
    );

    task automatic refill(input logic [VPN_W-1:0] vpn, input logic [PFN_W-1:0] pfn,
                          input logic [2:0] perm, input bit with_flush);
        @(negedge clk);
        wr_en = 1'b1; wr_vpn = vpn; wr_pfn = pfn; wr_perm = perm; flush = with_flush;
        @(negedge clk);
        wr_en = 1'b0; flush = 1'b0;
    endtask

    task automatic look(input string tag, input logic [VPN_W-1:0] vpn,
                        input logic [PAGE_BITS-1:0] off, input logic [1:0] acc,
                        input bit exp_hit, input logic [1:0] exp_fault,
                        input logic [PFN_W-1:0] exp_pfn);
        logic [PFN_W+PAGE_BITS-1:0] exp_pa;
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_acc = acc;
        #1;
        exp_pa = exp_hit ? {exp_pfn, off} : '0;
        checks++;
        if (lk_hit !== exp_hit || lk_fault !== exp_fault || lk_paddr !== exp_pa) begin
            errors++;
            $display("FAIL %s vpn=%0h: hit=%0b fault=%0d pa=%0h expected hit=%0b fault=%0d pa=%0h",
                     tag, vpn, lk_hit, lk_fault, lk_paddr, exp_hit, exp_fault, exp_pa);
        end
        lk_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        look("R1 empty after reset", 20'h5, 12'h0, 2'd0, 0, 2'd2, '0);
    endtask

    task automatic t_hit();
        refill(20'h5, 20'h123, 3'b111, 0);
        refill(20'h7, 20'h777, 3'b101, 0);
        look("R2 hit read", 20'h5, 12'hABC, 2'd0, 1, 2'd0, 20'h123);
        look("R3 offset kept", 20'h5, 12'hFFF, 2'd1, 1, 2'd0, 20'h123);
        look("R8 second slot exec", 20'h7, 12'h001, 2'd2, 1, 2'd0, 20'h777);
        look("R5 miss", 20'h6, 12'h010, 2'd0, 0, 2'd2, '0);
        @(negedge clk);
        lk_valid = 1'b0; lk_vaddr = {20'h5, 12'h3}; #1;
        checks++;
        if (lk_hit !== 1'b0 || lk_fault !== 2'd0 || lk_paddr !== '0) begin
            errors++;
            $display("FAIL R12 idle: hit=%0b fault=%0d pa=%0h expected 0 0 0", lk_hit, lk_fault, lk_paddr);
        end
    endtask

    task automatic t_perm();
        refill(20'h9, 20'h099, 3'b001, 0);
        refill(20'hA, 20'h0AA, 3'b100, 0);
        look("R6 read-only read", 20'h9, 12'h4, 2'd0, 1, 2'd0, 20'h099);
        look("R6 read-only write", 20'h9, 12'h4, 2'd1, 0, 2'd3, '0);
        look("R6 read-only exec", 20'h9, 12'h4, 2'd2, 0, 2'd3, '0);
        look("R6 exec-only read", 20'hA, 12'h8, 2'd0, 0, 2'd3, '0);
        look("R6 exec-only exec", 20'hA, 12'h8, 2'd2, 1, 2'd0, 20'h0AA);
        look("R6 code 3 refused", 20'h5, 12'h8, 2'd3, 0, 2'd3, '0);
    endtask

    task automatic t_limit();
        page_limit = 20'h8;
        look("R4 present above limit", 20'h9, 12'h0, 2'd0, 0, 2'd1, '0);
        look("R4 equal limit allowed", 20'h8, 12'h0, 2'd0, 0, 2'd2, '0);
        look("R7 limit over miss", 20'h14, 12'h0, 2'd0, 0, 2'd1, '0);
        look("R4 below limit hit", 20'h5, 12'h2, 2'd0, 1, 2'd0, 20'h123);
        page_limit = '1;
    endtask

    task automatic t_overwrite();
        refill(20'h5, 20'h456, 3'b001, 0);
        look("R10 overwritten frame", 20'h5, 12'h7, 2'd0, 1, 2'd0, 20'h456);
        look("R10 new flags", 20'h5, 12'h7, 2'd1, 0, 2'd3, '0);
        look("R10 neighbour kept", 20'h7, 12'h7, 2'd0, 1, 2'd0, 20'h777);
    endtask

    task automatic t_flush();
        refill(20'hB, 20'h0BB, 3'b111, 1);
        look("R11 flushed 5", 20'h5, 12'h0, 2'd0, 0, 2'd2, '0);
        look("R11 flushed 7", 20'h7, 12'h0, 2'd0, 0, 2'd2, '0);
        look("R11 write dropped", 20'hB, 12'h0, 2'd0, 0, 2'd2, '0);
    endtask

    task automatic t_roundrobin();
        for (int k = 0; k < ENTRIES; k++) refill(20'h20 + k, 20'h200 + k, 3'b001, 0);
        for (int k = 0; k < ENTRIES; k++)
            look("R8 fill keeps all", 20'h20 + k, 12'h0, 2'd0, 1, 2'd0, 20'h200 + k);
        refill(20'h50, 20'h500, 3'b001, 0);
        look("R9 slot0 evicted", 20'h20, 12'h0, 2'd0, 0, 2'd2, '0);
        look("R9 slot1 kept", 20'h21, 12'h0, 2'd0, 1, 2'd0, 20'h201);
        look("R9 new entry", 20'h50, 12'h0, 2'd0, 1, 2'd0, 20'h500);
        refill(20'h50, 20'h501, 3'b001, 0);
        refill(20'h51, 20'h510, 3'b001, 0);
        look("R9 pointer advanced", 20'h21, 12'h0, 2'd0, 0, 2'd2, '0);
        look("R10 pointer not moved by overwrite", 20'h22, 12'h0, 2'd0, 1, 2'd0, 20'h202);
        look("R10 overwrite in full array", 20'h50, 12'h0, 2'd0, 1, 2'd0, 20'h501);
    endtask

    initial begin
        t_reset();
        t_hit();
        t_perm();
        t_limit();
        t_overwrite();
        t_flush();
        t_roundrobin();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule